// File: doc/BRIEF.md
# Two-Bit Fast Serial Byte Sender

This block sends one byte, plus an end-of-data marker, from a controller to a peer over two shared open-collector lines, DATA and CLOCK. A third line, ATN, is never pulled. Each line driver is modelled as an active-high pull output. The DATA level seen on the wire comes back on a separate sense input. Bytes arrive on a valid/ready handshake. The block accepts a byte only while it is idle.

After accepting a byte, the block waits until the peer lets go of DATA. It then waits for a stall input to drop. The stall input tells the block that the next stretch of time would be cut short. When stall is low, the block releases both lines as a start mark. From that mark onward, everything runs on fixed cycle offsets with no handshake:

- Four slots follow, each carrying two bits of the byte, one bit on each line, in a scrambled pair order.
- A status slot then tells the peer whether this byte is the last one.
- Finally, the block pulls CLOCK. One cycle later it reports the DATA level it sensed, which is the peer's acknowledge.

Top module: `pairlink_tx`

## Requirements
- R1: After reset and in idle, `in_ready` is 1, `clock_pull` is 1, `data_pull` is 0, `atn_pull` is 0 and `ack_valid` is 0.
- R2: A byte and its `in_last` flag are captured on a clock edge where `in_valid` and `in_ready` are both 1. From that edge, `in_ready` is 0. It returns to 1 one cycle after the final CLOCK pull. `in_valid`, `in_data` and `in_last` are ignored while `in_ready` is 0.
- R3: No start mark is sent while the synchronized `data_sense` shows DATA pulled. `data_sense` passes through `SYNC_STAGES` flip-flops before it is used.
- R4: No start mark is sent while `stall` is 1. The start mark has `clock_pull`=0 and `data_pull`=0.
- R5: The line outputs change exactly `GAP_MARK`, `GAP_SLOT1`, `GAP_SLOT2`, `GAP_SLOT3`, `GAP_SLOT4` and `GAP_STATUS` cycles apart. The sequence is: start mark, slot 1, slot 2, slot 3, slot 4, status slot, final pull. The defaults are 11, 13, 11, 13, 13 and 13.
- R6: Slot 1 carries byte bit 5 on DATA and bit 4 on CLOCK. Slot 2 carries bit 7 on DATA and bit 6 on CLOCK.
- R7: Slot 3 carries bit 1 on DATA and bit 3 on CLOCK. Slot 4 carries bit 0 on DATA and bit 2 on CLOCK.
- R8: With `ONE_RELEASED`=1, a 1 bit is sent as pull=0 and a 0 bit as pull=1. With `ONE_RELEASED`=0, the encoding is inverted.
- R9: In the status slot, `data_pull` is 0. `clock_pull` equals the inverse of the captured `in_last`, whatever the polarity.
- R10: After the status slot, `clock_pull` goes to 1 and `data_pull` to 0. One cycle later, `ack_valid` pulses for one cycle and `ack_data` holds the synchronized `data_sense`.
- R11: `atn_pull` stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block idle, byte can be taken |
| in_data | input | 8 | Byte to send |
| in_last | input | 1 | End-of-data marker for this byte |
| stall | input | 1 | High while the coming window is too short to start |
| data_sense | input | 1 | Sensed DATA level, 1 = pulled |
| data_pull | output | 1 | Pull DATA active |
| clock_pull | output | 1 | Pull CLOCK active |
| atn_pull | output | 1 | Pull ATN active, always 0 |
| ack_valid | output | 1 | One-cycle pulse when the acknowledge is sampled |
| ack_data | output | 1 | Sampled DATA level, valid with `ack_valid` |

## Verification
The assertions assume that `rst` is high from time zero for at least one edge. They also assume that `stall` and `in_valid` are synchronous to `clk`. The slot checks assume that the peer leaves DATA released from the start mark until the status slot. The stimulus follows both assumptions:

- The bench drives every input on the falling clock edge.
- It keeps `data_sense` low through the slots.
- It raises `data_sense` for an acknowledge only after sampling the status slot, and drops it again once `ack_valid` has been seen.

// File: rtl/pairlink_pkg.sv
package pairlink_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAITR  = 3'd1,
    ST_WINDOW = 3'd2,
    ST_SLOTS  = 3'd3,
    ST_ACK    = 3'd4
  } tx_state_t;

  typedef struct packed {
    logic dpull;
    logic cpull;
  } line_pair_t;

  localparam int NUM_PHASES = 6;
  localparam int NUM_SLOTS  = 4;
  localparam int PH_W       = 3;

endpackage

// File: rtl/pairlink_sync.sv
module pairlink_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      logic unused_rst;
      assign unused_rst = rst;
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pairlink_gap_timer.sv
module pairlink_gap_timer #(
  parameter int CW   = 4,
  parameter int MAXV = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val - CW'(1);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);

  // a loaded count never exceeds the longest gap
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(MAXV)); // R5

  // a nonzero count falls by one each idle cycle
  AST_GAP_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> cnt == $past(cnt) - CW'(1)); // R5
endmodule

// File: rtl/pairlink_slot_map.sv
module pairlink_slot_map
  import pairlink_pkg::*;
#(
  parameter bit ONE_RELEASED = 1'b1
) (
  input  logic                        [7:0] byte_i,
  input  logic                              last_i,
  output line_pair_t [NUM_PHASES-1:0]       pat_o
);
  localparam int DBIT [NUM_SLOTS] = '{5, 7, 1, 0};
  localparam int CBIT [NUM_SLOTS] = '{4, 6, 3, 2};

  // phase 0: start mark, both released
  assign pat_o[0] = '{dpull: 1'b0, cpull: 1'b0};

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (ONE_RELEASED) begin : g_rel
        assign pat_o[s+1] = '{dpull: ~byte_i[DBIT[s]], cpull: ~byte_i[CBIT[s]]};
      end else begin : g_pull
        assign pat_o[s+1] = '{dpull: byte_i[DBIT[s]], cpull: byte_i[CBIT[s]]};
      end
    end
  endgenerate

  // status phase: DATA released, CLOCK released only on end of data
  assign pat_o[NUM_PHASES-1] = '{dpull: 1'b0, cpull: ~last_i};
endmodule

// File: rtl/pairlink_tx.sv
module pairlink_tx
  import pairlink_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter bit ONE_RELEASED = 1'b1,
  parameter int GAP_MARK     = 11,
  parameter int GAP_SLOT1    = 13,
  parameter int GAP_SLOT2    = 11,
  parameter int GAP_SLOT3    = 13,
  parameter int GAP_SLOT4    = 13,
  parameter int GAP_STATUS   = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       stall,
  input  logic       data_sense,
  output logic       data_pull,
  output logic       clock_pull,
  output logic       atn_pull,
  output logic       ack_valid,
  output logic       ack_data
);
  localparam int GAPS [NUM_PHASES] =
    '{GAP_MARK, GAP_SLOT1, GAP_SLOT2, GAP_SLOT3, GAP_SLOT4, GAP_STATUS};

  function automatic int max_gap();
    int m = 1;
    for (int i = 0; i < NUM_PHASES; i++) if (GAPS[i] > m) m = GAPS[i];
    return m;
  endfunction

  localparam int MAXG = max_gap();
  localparam int CW   = $clog2(MAXG + 1);

  tx_state_t                    st;
  logic [7:0]                   byte_q;
  logic                         last_q;
  logic [PH_W-1:0]              ph;
  logic                         data_s;
  logic                         tmr_load;
  logic [CW-1:0]                tmr_val;
  logic                         tmr_done;
  line_pair_t [NUM_PHASES-1:0]  pat;

  pairlink_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (data_sense),
    .q   (data_s)
  );

  pairlink_slot_map #(.ONE_RELEASED(ONE_RELEASED)) u_map (
    .byte_i (byte_q),
    .last_i (last_q),
    .pat_o  (pat)
  );

  pairlink_gap_timer #(.CW(CW), .MAXV(MAXG)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  // timer load decision
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CW'(GAPS[0]);
    if (st == ST_WINDOW && !stall) begin
      tmr_load = 1'b1;
    end else if (st == ST_SLOTS && tmr_done && ph != PH_W'(NUM_PHASES-1)) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(GAPS[ph + PH_W'(1)]);
    end
  end

  assign atn_pull = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      in_ready   <= 1'b1;
      byte_q     <= '0;
      last_q     <= 1'b0;
      ph         <= '0;
      data_pull  <= 1'b0;
      clock_pull <= 1'b1;
      ack_valid  <= 1'b0;
      ack_data   <= 1'b0;
    end else begin
      ack_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (in_valid && in_ready) begin
            byte_q   <= in_data;
            last_q   <= in_last;
            in_ready <= 1'b0;
            st       <= ST_WAITR;
          end
        end
        ST_WAITR: begin
          if (!data_s) st <= ST_WINDOW;
        end
        ST_WINDOW: begin
          if (!stall) begin
            data_pull  <= pat[0].dpull;
            clock_pull <= pat[0].cpull;
            ph         <= '0;
            st         <= ST_SLOTS;
          end
        end
        ST_SLOTS: begin
          if (tmr_done) begin
            if (ph == PH_W'(NUM_PHASES-1)) begin
              data_pull  <= 1'b0;
              clock_pull <= 1'b1;
              st         <= ST_ACK;
            end else begin
              ph         <= ph + PH_W'(1);
              data_pull  <= pat[ph + PH_W'(1)].dpull;
              clock_pull <= pat[ph + PH_W'(1)].cpull;
            end
          end
        end
        ST_ACK: begin
          ack_valid <= 1'b1;
          ack_data  <= data_s;
          in_ready  <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (clock_pull && !data_pull)); // R1

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_HOLD_PEER: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAITR) |=> (clock_pull && !data_pull)); // R3

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WINDOW && stall) |=> (clock_pull && !data_pull && st == ST_WINDOW)); // R4

  AST_STATUS_DATA: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLOTS && ph == PH_W'(NUM_PHASES-1)) |-> !data_pull); // R9

  AST_ACK_AFTER_PULL: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ($past(clock_pull) && !$past(in_ready) && in_ready)); // R10

  AST_ATN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> !atn_pull); // R11
endmodule

// File: tb/pairlink_tx_tb.sv
module pairlink_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       stall = 1'b0;
  logic       data_sense = 1'b0;
  logic       rdy_a, dp_a, cp_a, atn_a, av_a, ad_a;
  logic       rdy_b, dp_b, cp_b, atn_b, av_b, ad_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pairlink_tx #(.ONE_RELEASED(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_a),
    .in_data(in_data), .in_last(in_last), .stall(stall),
    .data_sense(data_sense), .data_pull(dp_a), .clock_pull(cp_a),
    .atn_pull(atn_a), .ack_valid(av_a), .ack_data(ad_a));

  pairlink_tx #(.ONE_RELEASED(1'b0)) u_dut_inv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_b),
    .in_data(in_data), .in_last(in_last), .stall(stall),
    .data_sense(data_sense), .data_pull(dp_b), .clock_pull(cp_b),
    .atn_pull(atn_b), .ack_valid(av_b), .ack_data(ad_b));

  // cycle offsets from the start mark
  localparam int OFF_S1 = 11, OFF_S2 = 24, OFF_S3 = 35, OFF_S4 = 48;
  localparam int OFF_ST = 61, OFF_END = 74;

  // vectors: {byte, last, peer_ack}
  localparam int NV = 6;
  localparam logic [9:0] VEC [NV] = '{
    {8'hA5, 1'b0, 1'b1}, {8'h00, 1'b1, 1'b0}, {8'hFF, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1}, {8'h81, 1'b0, 1'b1}, {8'h5A, 1'b1, 1'b0}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic dec(input logic pull, input bit one_rel);
    return one_rel ? ~pull : pull;
  endfunction

  task automatic run_xfer(input logic [7:0] b, input logic last, input logic ack,
                          input int peer_hold, input int stall_hold, input bit noise);
    logic [7:0] ra, rb;
    bit seen;
    ra = '0; rb = '0;
    if (peer_hold > 0) data_sense = 1'b1;
    if (stall_hold > 0) stall = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = last;
    @(negedge clk);
    in_valid = 1'b0;
    check(!rdy_a && !rdy_b, "R2 ready low after accept", rdy_a, 0);
    if (peer_hold > 0) begin
      repeat (peer_hold) @(negedge clk);
      check(cp_a && cp_b && !dp_a, "R3 no mark while DATA held", cp_a, 1);
      data_sense = 1'b0;
    end
    if (stall_hold > 0) begin
      repeat (stall_hold) @(negedge clk);
      check(cp_a && cp_b && !dp_a, "R4 no mark while stalled", cp_a, 1);
      stall = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < 500 && !seen; i++) begin
      @(negedge clk);
      if (!cp_a) seen = 1'b1;
    end
    check(seen && !dp_a && !cp_b && !dp_b, "R4 start mark released", {cp_b, dp_a}, 0);
    check(!atn_a && !atn_b, "R11 atn idle", atn_a, 0);
    if (noise) begin
      in_valid = 1'b1; in_data = ~b; in_last = ~last;
    end
    for (int off = 1; off <= OFF_END + 1; off++) begin
      @(negedge clk);
      case (off)
        OFF_S1 - 1: check(!dp_a && !cp_a, "R5 mark held full gap", {dp_a, cp_a}, 0);
        OFF_S1 + 6: begin
          ra[5] = dec(dp_a, 1); ra[4] = dec(cp_a, 1);
          rb[5] = dec(dp_b, 0); rb[4] = dec(cp_b, 0);
        end
        OFF_S2 + 5: begin
          ra[7] = dec(dp_a, 1); ra[6] = dec(cp_a, 1);
          rb[7] = dec(dp_b, 0); rb[6] = dec(cp_b, 0);
        end
        OFF_S3 + 6: begin
          ra[1] = dec(dp_a, 1); ra[3] = dec(cp_a, 1);
          rb[1] = dec(dp_b, 0); rb[3] = dec(cp_b, 0);
        end
        OFF_S4 + 6: begin
          ra[0] = dec(dp_a, 1); ra[2] = dec(cp_a, 1);
          rb[0] = dec(dp_b, 0); rb[2] = dec(cp_b, 0);
        end
        OFF_ST + 6: begin
          check(!dp_a && !dp_b, "R9 status DATA released", {dp_a, dp_b}, 0);
          check(cp_a == ~last && cp_b == ~last, "R9 status CLOCK", cp_a, ~last);
          check(!rdy_a && !rdy_b, "R2 ready low in transfer", rdy_a, 0);
          data_sense = ack;
        end
        OFF_END - 1: begin
          check(cp_a == ~last, "R5 status held full gap", cp_a, ~last);
          in_valid = 1'b0;
        end
        OFF_END: begin
          check(cp_a && cp_b && !dp_a && !dp_b, "R10 final CLOCK pull", {cp_a, dp_a}, 2);
          check(!av_a && !rdy_a, "R10 no ack yet", av_a, 0);
        end
        OFF_END + 1: begin
          check(av_a && av_b, "R10 ack pulse", {av_a, av_b}, 3);
          check(ad_a == ack && ad_b == ack, "R10 ack data", ad_a, ack);
          check(rdy_a && rdy_b, "R2 ready back", rdy_a, 1);
        end
        default: ;
      endcase
    end
    data_sense = 1'b0;
    check(ra[7:4] == b[7:4], "R6 slots 1-2 bits", ra[7:4], b[7:4]);
    check(ra[3:0] == b[3:0], "R7 slots 3-4 bits", ra[3:0], b[3:0]);
    check(rb == b, "R8 inverted polarity byte", rb, b);
    @(negedge clk);
    check(!av_a, "R10 ack single cycle", av_a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rdy_a && cp_a && !dp_a && !atn_a && !av_a, "R1 reset state",
          {rdy_a, cp_a, dp_a, atn_a, av_a}, 5'b11000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(rdy_b && cp_b && !dp_b && !atn_b, "R1 idle after reset", {rdy_b, cp_b, dp_b}, 3'b110);
    for (int v = 0; v < NV; v++)
      run_xfer(VEC[v][9:2], VEC[v][1], VEC[v][0], 0, 0, 1'b0);
    run_xfer(8'h96, 1'b0, 1'b1, 40, 0, 1'b0);   // R3
    run_xfer(8'h69, 1'b1, 1'b0, 0, 50, 1'b0);   // R4
    run_xfer(8'hC3, 1'b0, 1'b1, 0, 0, 1'b1);    // R2 ignore while busy
    run_xfer(8'h18, 1'b1, 1'b1, 20, 30, 1'b0);  // R3 and R4 together
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule